// File: doc/BRIEF.md
# Clamped PI Oscillator Tuning Filter

This block is the loop filter of a clock-recovery servo. Each time a detector produces a signed error sample, the filter updates an integrator and forms a new signed tuning word for a digitally controlled oscillator. The tuning word is a base offset plus a proportional term plus the integrator. It is limited to a fixed symmetric range that the oscillator's tuning resolution allows. A synchronous clear returns the loop to a neutral state. The caller uses the clear when the reference is switched or when the loop is started again.

A parameter selects one of two gain sets. The main (phase-locking) loop multiplies the error by 12 for the proportional term and by 2 for the integrator. The helper (period-locking) loop multiplies the error by 2 for the proportional term and by one half for the integrator. The integrator is advanced first, so each sample's own integral contribution is already present in the word produced for that sample.

Top module: `pi_tune_filter`

## Requirements
- R1: While reset (rst_n low at a clock edge) is applied, tune_out is 0 and tune_vld is 0 after that edge, and the integrator is zero: the first sample after reset gives the same word as a sample taken right after a clear.
- R2: With LOOP = main, each accepted sample e with base b first adds 2*e to the integrator I. The output is then b + 12*e + I, where I is the updated value.
- R3: With LOOP = helper, each accepted sample e first adds floor(e/2) to the integrator, an arithmetic shift toward negative infinity. For example, e = -3 adds -2. The output is then b + 2*e + I, where I is the updated value.
- R4: The integrator is updated before the output is formed. The very first sample after a clear already carries its own integral term, so the main loop with e = 5 and b = 100 gives 170.
- R5: tune_out is saturated to the range [-8161512, +8161512]. A sum above the range gives +8161512, and a sum below it gives -8161512.
- R6: A cycle with clr high zeroes the integrator, sets tune_out to 0 and holds tune_vld at 0 after that edge.
- R7: An error sample offered while clr is high is ignored. It produces no tune_vld pulse and leaves no trace in the integrator.
- R8: tune_vld is high for exactly the one cycle after each accepted sample (err_vld high and clr low). tune_out holds its value in cycles without an accepted sample or a clear.
- R9: base_in is taken in the same cycle as the error sample, and its value in other cycles has no effect.
- R10: Intermediate sums do not wrap. Full-scale 32-bit errors, which would overflow a 32-bit sum, still saturate to the correct sign.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clr | input | 1 | Synchronous loop clear (integrator and output to zero) |
| err_vld | input | 1 | Error sample strobe |
| err_in | input | ERR_W (32) | Signed error sample |
| base_in | input | BASE_W (32) | Signed base offset added to every tuning word |
| tune_vld | output | 1 | One-cycle strobe marking a new tuning word |
| tune_out | output | TUNE_W (24) | Signed saturated tuning word |

## Verification
A corrupted integrator does not appear at the ports on its own. It shows up as a wrong tuning word on the next accepted sample, and the error persists on every later sample until a clear. A reference model that compares on every clock therefore detects it within one sample period. A wrong strobe or a missing hold shows up in the cycle after the offending input. Saturation errors show up only with large errors or a large integrator, so full-scale inputs of both signs are driven for both gain sets.

// File: rtl/pi_tune_pkg.sv
// Package: shared accumulator type and loop-variant selector for the
// PI tuning filter. Assumes 48-bit accumulation covers 12x a 32-bit
// error plus a 32-bit base plus a bounded integrator history.
package pi_tune_pkg;
    localparam int ACC_W = 48;
    typedef logic signed [ACC_W-1:0] acc_t;
    typedef enum logic {
        LOOP_HELPER = 1'b0,
        LOOP_MAIN   = 1'b1
    } loop_e;
endpackage

// File: rtl/pi_gain_terms.sv
// Module: pi_gain_terms
// Forms the proportional term and the integrator increment from one
// error sample, for the gain set chosen by LOOP. Purely combinational;
// assumes ERR_W is well below ACC_W so shifts cannot lose sign.
module pi_gain_terms
    import pi_tune_pkg::*;
#(
    parameter int    ERR_W = 32,
    parameter loop_e LOOP  = LOOP_MAIN
) (
    input  logic signed [ERR_W-1:0] err,
    output acc_t                    prop,
    output acc_t                    inc
);
    localparam int EXT_W = ACC_W - ERR_W;

    acc_t err_ext;

    // Sign-extend the error to the accumulator width.
    always_comb err_ext = {{EXT_W{err[ERR_W-1]}}, err};

    generate
        if (LOOP == LOOP_MAIN) begin : g_main
            // Main set: proportional x12 (8+4), integral x2.
            always_comb begin
                prop = (err_ext <<< 3) + (err_ext <<< 2);
                inc  = err_ext <<< 1;
            end
        end else begin : g_helper
            // Helper set: proportional x2, integral x0.5 rounded down.
            always_comb begin
                prop = err_ext <<< 1;
                inc  = err_ext >>> 1;
            end
        end
    endgenerate
endmodule

// File: rtl/pi_integrator.sv
// Module: pi_integrator
// Holds the loop integrator. Exposes the value it will take if the
// current sample is accepted, so the output path can use the updated
// value in the same cycle. Assumes clr has priority over load.
module pi_integrator
    import pi_tune_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic load,
    input  acc_t inc,
    output acc_t acc_q,
    output acc_t acc_nxt
);
    // Candidate next value for an accepted sample.
    always_comb acc_nxt = acc_q + inc;

    // Integrator register: zero on reset or clear, advance on load.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            acc_q <= '0;
        end else if (load) begin
            acc_q <= acc_nxt;
        end
    end

    // R6
    acc_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (acc_q == '0));

    // R7
    acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !clr) |=> $stable(acc_q));
endmodule

// File: rtl/pi_saturate.sv
// Module: pi_saturate
// Clamps a wide signed sum to the symmetric range +/-LIMIT and narrows
// it to TUNE_W bits. Assumes LIMIT fits in a signed TUNE_W word.
module pi_saturate
    import pi_tune_pkg::*;
#(
    parameter int TUNE_W = 24,
    parameter int LIMIT  = 8161512
) (
    input  acc_t                     val,
    output logic signed [TUNE_W-1:0] sat
);
    localparam acc_t HI = acc_t'(LIMIT);
    localparam acc_t LO = -HI;

    // Select the bound or the in-range value.
    always_comb begin
        if (val > HI) begin
            sat = HI[TUNE_W-1:0];
        end else if (val < LO) begin
            sat = LO[TUNE_W-1:0];
        end else begin
            sat = val[TUNE_W-1:0];
        end
    end
endmodule

// File: rtl/pi_tune_filter.sv
// Module: pi_tune_filter (top)
// Proportional-integral loop filter producing an oscillator tuning
// word from signed error samples. For each accepted sample, the
// integrator is advanced first, then base + proportional + integrator
// is saturated and registered with a one-cycle valid strobe.
// Assumes: clr is synchronous and overrides a simultaneous sample.
module pi_tune_filter
    import pi_tune_pkg::*;
#(
    parameter int    ERR_W  = 32,
    parameter int    BASE_W = 32,
    parameter int    TUNE_W = 24,
    parameter int    LIMIT  = 8161512,
    parameter loop_e LOOP   = LOOP_MAIN
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     err_vld,
    input  logic signed [ERR_W-1:0]  err_in,
    input  logic signed [BASE_W-1:0] base_in,
    output logic                     tune_vld,
    output logic signed [TUNE_W-1:0] tune_out
);
    localparam int BEXT_W = ACC_W - BASE_W;

    logic                     take;
    acc_t                     prop;
    acc_t                     inc;
    acc_t                     acc_q;
    acc_t                     acc_nxt;
    acc_t                     base_ext;
    acc_t                     sum;
    logic signed [TUNE_W-1:0] sat_word;

    // A sample counts only when no clear is pending.
    always_comb take = err_vld && !clr;

    pi_gain_terms #(
        .ERR_W (ERR_W),
        .LOOP  (LOOP)
    ) gain_i (
        .err  (err_in),
        .prop (prop),
        .inc  (inc)
    );

    pi_integrator integ_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .load    (take),
        .inc     (inc),
        .acc_q   (acc_q),
        .acc_nxt (acc_nxt)
    );

    // Full-width sum using the already-updated integrator.
    always_comb begin
        base_ext = {{BEXT_W{base_in[BASE_W-1]}}, base_in};
        sum      = base_ext + prop + acc_nxt;
    end

    pi_saturate #(
        .TUNE_W (TUNE_W),
        .LIMIT  (LIMIT)
    ) sat_i (
        .val (sum),
        .sat (sat_word)
    );

    // Output register: zero on reset/clear, load on accepted sample.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            tune_out <= '0;
            tune_vld <= 1'b0;
        end else begin
            tune_vld <= take;
            if (take) begin
                tune_out <= sat_word;
            end
        end
    end

    // R8
    vld_after_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_vld && !clr) |=> tune_vld);

    // R8
    vld_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(err_vld && !clr) |=> !tune_vld);

    // R8
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!err_vld && !clr) |=> $stable(tune_out));

    // R6
    clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (tune_out == '0 && !tune_vld));

    // R5
    clamp_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tune_vld |-> (tune_out <= LIMIT && tune_out >= -LIMIT));
endmodule

// File: tb/pi_tune_filter_tb_top.sv
// Bench: drives one main-loop and one helper-loop instance with the
// same stimulus and compares both against a behavioural model on
// every clock, plus hand-computed spot values.
module pi_tune_filter_tb_top;
    import pi_tune_pkg::*;

    localparam longint LIM = 8161512;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               clr = 1'b0;
    logic               err_vld = 1'b0;
    logic signed [31:0] err_in = '0;
    logic signed [31:0] base_in = '0;
    logic               m_vld_o, h_vld_o;
    logic signed [23:0] m_out_o, h_out_o;

    int     checks = 0;
    int     fails = 0;
    bit     cmp_en = 1'b0;
    bit     done = 1'b0;
    string  cur_req = "R1";

    // Model state.
    longint mi = 0, mo = 0, hi = 0, ho = 0;
    bit     mv = 0, hv = 0;

    always #5 clk = ~clk;

    pi_tune_filter #(.LOOP(LOOP_MAIN)) dut_i (
        .clk(clk), .rst_n(rst_n), .clr(clr), .err_vld(err_vld),
        .err_in(err_in), .base_in(base_in),
        .tune_vld(m_vld_o), .tune_out(m_out_o));

    pi_tune_filter #(.LOOP(LOOP_HELPER)) dut_h_i (
        .clk(clk), .rst_n(rst_n), .clr(clr), .err_vld(err_vld),
        .err_in(err_in), .base_in(base_in),
        .tune_vld(h_vld_o), .tune_out(h_out_o));

    function automatic longint clampv(longint v);
        if (v > LIM) return LIM;
        if (v < -LIM) return -LIM;
        return v;
    endfunction

    function automatic longint half_floor(longint e);
        if (e < 0 && (e % 2) != 0) return e / 2 - 1;
        return e / 2;
    endfunction

    task automatic chk(string req, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Reference model, advanced at each rising edge.
    always @(posedge clk) begin
        longint e, b;
        e = err_in;
        b = base_in;
        if (!rst_n || clr) begin
            mi = 0; mo = 0; mv = 0;
            hi = 0; ho = 0; hv = 0;
        end else if (err_vld) begin
            mi = mi + 2 * e;
            mo = clampv(b + 12 * e + mi);
            mv = 1;
            hi = hi + half_floor(e);
            ho = clampv(b + 2 * e + hi);
            hv = 1;
        end else begin
            mv = 0;
            hv = 0;
        end
    end

    // Every-cycle comparison, away from the active edge.
    always @(negedge clk) begin
        if (cmp_en && !done) begin
            chk(cur_req, "main word", longint'(m_out_o), mo);
            chk(cur_req, "main strobe", longint'(m_vld_o), longint'(mv));
            chk(cur_req, "helper word", longint'(h_out_o), ho);
            chk(cur_req, "helper strobe", longint'(h_vld_o), longint'(hv));
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    // Present one sample for one cycle, then drop the strobe.
    task automatic send(longint e, longint b);
        @(negedge clk);
        err_vld = 1'b1;
        err_in  = 32'(e);
        base_in = 32'(b);
        @(negedge clk);
        err_vld = 1'b0;
    endtask

    task automatic do_clear();
        @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R8 watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        // R1: reset state.
        repeat (3) @(negedge clk);
        chk("R1", "reset main word", longint'(m_out_o), 0);
        chk("R1", "reset main strobe", longint'(m_vld_o), 0);
        chk("R1", "reset helper word", longint'(h_out_o), 0);
        rst_n = 1'b1;
        cmp_en = 1'b1;

        // R2 R3 R4: hand values for the first samples after reset.
        cur_req = "R4";
        send(5, 100);
        chk("R4", "main first", longint'(m_out_o), 170);
        chk("R3", "helper first", longint'(h_out_o), 112);
        chk("R8", "strobe after sample", longint'(m_vld_o), 1);
        cur_req = "R2";
        send(-3, 0);
        chk("R2", "main second", longint'(m_out_o), -32);
        chk("R3", "helper floor shift", longint'(h_out_o), -6);

        // R8 R9: hold between samples while base moves.
        cur_req = "R9";
        @(negedge clk);
        base_in = 32'sd777777;
        repeat (4) @(negedge clk);
        chk("R9", "base ignored idle", longint'(m_out_o), -32);
        chk("R8", "strobe low idle", longint'(m_vld_o), 0);

        // R6 R7: sample during clear is dropped, integrator zeroed.
        cur_req = "R7";
        @(negedge clk);
        clr = 1'b1; err_vld = 1'b1; err_in = 32'sd4000; base_in = 0;
        @(negedge clk);
        clr = 1'b0; err_vld = 1'b0;
        chk("R6", "clear word", longint'(m_out_o), 0);
        chk("R7", "no strobe in clear", longint'(m_vld_o), 0);
        send(5, 100);
        chk("R7", "integrator untouched", longint'(m_out_o), 170);

        // R5 R10: full-scale errors saturate both ways.
        cur_req = "R10";
        do_clear();
        send(64'sh7FFF_FFFF, 64'sh7FFF_FFFF);
        chk("R5", "main pos clamp", longint'(m_out_o), LIM);
        chk("R10", "helper pos clamp", longint'(h_out_o), LIM);
        do_clear();
        send(-64'sh8000_0000, -64'sh8000_0000);
        chk("R5", "main neg clamp", longint'(m_out_o), -LIM);
        chk("R10", "helper neg clamp", longint'(h_out_o), -LIM);
        send(-64'sh8000_0000, 0);
        chk("R10", "repeat neg clamp", longint'(m_out_o), -LIM);
        do_clear();

        // R5: just across the limit.
        cur_req = "R5";
        send(0, LIM + 1);
        chk("R5", "one above limit", longint'(m_out_o), LIM);
        send(0, -LIM);
        chk("R5", "at negative limit", longint'(m_out_o), -LIM);

        // R2 R3: back-to-back samples, odd negative errors.
        cur_req = "R3";
        do_clear();
        @(negedge clk);
        err_vld = 1'b1;
        for (int k = 0; k < 40; k++) begin
            err_in  = 32'(-(2 * k + 1));
            base_in = 32'(k * 10);
            @(negedge clk);
        end
        err_vld = 1'b0;

        // R2 R3 R6 R8 R9: random traffic with occasional clears.
        cur_req = "R2 R3 R9";
        for (int k = 0; k < 4000; k++) begin
            @(negedge clk);
            err_vld = ($urandom % 2) == 0;
            err_in  = 32'($signed($urandom % 131072) - 65536);
            base_in = 32'($signed($urandom % 2097152) - 1048576);
            clr     = ($urandom % 64) == 0;
        end
        @(negedge clk);
        err_vld = 1'b0;
        clr = 1'b0;
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule